// File: doc/BRIEF.md
# Split-Tenure Bus Arbiter

This block is the central arbiter of a shared bus whose address phase and data phase are granted on separate wires. Each master raises one request line. The arbiter answers with an address grant, and later with a data grant, on per-master one-hot vectors. It follows the transfer-start, address-acknowledge, transfer-acknowledge and address-retry strobes, and from them it produces its own address-busy and data-busy flags.

A 3-bit preference level for each master and a park selector come in as static configuration. Masters at the same level take turns. Each acknowledged address tenure joins a short in-order queue, and data grants are handed out from that queue. This lets the next address tenure run while an earlier data tenure is still moving beats.

Top module: `split_tenure_arbiter`

## Requirements
- R1: While `rst_n` is low (sampled synchronously), `addr_gnt` equals the one-hot of `park_sel`, `data_gnt` is zero, and both busy flags are low. Each of these holds one clock after the reset edge.
- R2: When no request is raised and the address bus is free, `addr_gnt` moves to the one-hot of `park_sel` one clock later.
- R3: Master m's level is `lvl_cfg[3m+2:3m]`. A larger value is preferred, and the grant goes to a requester at the highest level present.
- R4: Ties among requesters at the top level are settled round-robin. The search starts at the master after the one that last started an address tenure. The pointer is 0 after reset.
- R5: `ts_in` starts an address tenure only when `addr_gnt` is non-zero and both `addr_busy` and `artry_in` are low. `addr_busy` is then high one clock later. Any other `ts_in` is ignored.
- R6: `aack_in` while `addr_busy` is high clears `addr_busy` at the next edge. `addr_gnt` does not change while `addr_busy` is high, except at the edge that ends the tenure.
- R7: An `artry_in` that arrives with the ending `aack_in` cancels the tenure. No data grant follows from it.
- R8: Data grants follow the order in which tenures were acknowledged. With the data bus idle, the grant appears two edges after `aack_in`. `data_busy` rises at the next edge when `artry_in` is low.
- R9: A data tenure ends on its 1st `ta_in` if `burst_in` was low at transfer start, and on its 4th if it was high. At that edge `data_busy` falls, and `data_gnt` moves to the next queued master, or to zero if the queue is empty.
- R10: An address grant and a new address tenure can take place while `data_busy` is high.
- R11: When the order queue (2 entries) would be full after the current edge, `addr_gnt` is driven to zero. It is granted again once an entry leaves.
- R12: At most one bit of `addr_gnt` and at most one bit of `data_gnt` are high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | NUM_M | Request line per master |
| lvl_cfg | input | 3*NUM_M | Preference level per master |
| park_sel | input | IDW | Master parked on the address bus when idle |
| ts_in | input | 1 | Transfer start from the address-granted master |
| burst_in | input | 1 | Burst flag, sampled together with an accepted transfer start |
| aack_in | input | 1 | Address acknowledge |
| artry_in | input | 1 | Address retry |
| ta_in | input | 1 | Transfer acknowledge, one per data beat |
| addr_gnt | output | NUM_M | One-hot address grant |
| data_gnt | output | NUM_M | One-hot data grant |
| addr_busy | output | 1 | Address tenure in progress |
| data_busy | output | 1 | Data tenure in progress |

## Verification
Each result has a fixed latency. A request change shows on `addr_gnt` one edge later. An accepted transfer start raises `addr_busy` one edge later. An acknowledge raises the data grant two edges later, and `data_busy` follows one edge after that. The final beat drops `data_busy` at its own edge. The bench drives inputs and samples outputs on the falling clock edge, and it counts the rising edges between stimulus and check to match these latencies. Expected grants come from a priority and rotation model in the bench, which is swept over every request pattern under several level maps.

// File: rtl/sbarb_pkg.sv
// Shared constants for the split-tenure arbiter.
// Assumes: preference levels are 3 bits wide (eight levels).
package sbarb_pkg;
    localparam int LVL_W = 3;
    localparam int DEF_BURST_BEATS = 4;
endpackage

// File: rtl/sbarb_prio_pick.sv
// Combinational winner selection: highest level first, then round-robin from rr_ptr.
// Assumes: rr_ptr < N; any_req low means win_id is don't-care.
module sbarb_prio_pick #(
    parameter int N     = 4,
    parameter int LVL_W = 3,
    parameter int IDW   = 2
) (
    input  logic [N-1:0]       req,
    input  logic [N*LVL_W-1:0] lvl,
    input  logic [IDW-1:0]     rr_ptr,
    output logic               any_req,
    output logic [IDW-1:0]     win_id
);
    logic [LVL_W-1:0] top_lvl;
    logic [N-1:0]     cand;
    logic             found;

    // Find the highest level among active requesters.
    always_comb begin
        top_lvl = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (lvl[i*LVL_W +: LVL_W] > top_lvl)) top_lvl = lvl[i*LVL_W +: LVL_W];
        end
    end

    // Mark requesters sitting at that level.
    always_comb begin
        for (int i = 0; i < N; i++) cand[i] = req[i] && (lvl[i*LVL_W +: LVL_W] == top_lvl);
    end

    // Rotate from rr_ptr to the first candidate.
    always_comb begin
        win_id = '0;
        found  = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = int'(rr_ptr) + k;
            if (idx >= N) idx = idx - N;
            if (!found && cand[idx]) begin
                win_id = IDW'(idx);
                found  = 1'b1;
            end
        end
    end

    assign any_req = |req;
endmodule

// File: rtl/sbarb_order_fifo.sv
// In-order queue of acknowledged address tenures (master id + burst flag).
// Assumes: caller never pushes into a full queue or pops an empty one.
module sbarb_order_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full_next
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic [CW:0]   cnt_nxt;

    // Occupancy after this edge, used to hold off new address grants.
    always_comb begin
        cnt_nxt = {1'b0, cnt};
        if (push) cnt_nxt = cnt_nxt + 1'b1;
        if (pop)  cnt_nxt = cnt_nxt - 1'b1;
    end
    assign full_next = (cnt_nxt >= (CW+1)'(DEPTH));
    assign empty     = (cnt == '0);
    assign dout      = mem[rd_ptr];

    // Pointer and count update with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + PW'(1);
            if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + PW'(1);
            cnt <= cnt_nxt[CW-1:0];
        end
    end

    // Entry storage.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt < CW'(DEPTH)) || pop);                                  // R11
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt != '0));                                                 // R8
endmodule

// File: rtl/sbarb_addr_trk.sv
// Address-bus side: grant register, busy tenure, round-robin pointer, queue push.
// Assumes: ts_in comes from the master holding the address grant.
module sbarb_addr_trk #(
    parameter int N   = 4,
    parameter int IDW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ts_in,
    input  logic           burst_in,
    input  logic           aack_in,
    input  logic           artry_in,
    input  logic           any_req,
    input  logic [IDW-1:0] win_id,
    input  logic [IDW-1:0] park_id,
    input  logic           block_grant,
    output logic [N-1:0]   agnt,
    output logic           abusy,
    output logic [IDW-1:0] rr_ptr,
    output logic           push,
    output logic [IDW-1:0] push_id,
    output logic           push_burst
);
    logic [N-1:0]   agnt_q;
    logic           abusy_q;
    logic [IDW-1:0] rr_q, own_q, grant_id, nxt_id;
    logic           bst_q, take, ending, may_change;
    logic [N-1:0]   nxt_vec, park_vec;

    // Encode the held one-hot grant.
    always_comb begin
        grant_id = '0;
        for (int i = 0; i < N; i++) if (agnt_q[i]) grant_id = IDW'(i);
    end

    assign take       = ts_in && !abusy_q && !artry_in && (|agnt_q);
    assign ending     = abusy_q && aack_in;
    assign may_change = (!abusy_q && !take) || ending;
    assign nxt_id     = any_req ? win_id : park_id;

    // Candidate grant vectors: arbitration result and park position.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            nxt_vec[i]  = (nxt_id == IDW'(i)) && !block_grant;
            park_vec[i] = (park_id == IDW'(i));
        end
    end

    // Tenure state, owner capture and rotation pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abusy_q <= 1'b0;
            own_q   <= '0;
            bst_q   <= 1'b0;
            rr_q    <= '0;
        end else if (take) begin
            abusy_q <= 1'b1;
            own_q   <= grant_id;
            bst_q   <= burst_in;
            rr_q    <= (grant_id == IDW'(N-1)) ? '0 : grant_id + IDW'(1);
        end else if (ending) begin
            abusy_q <= 1'b0;
        end
    end

    // Grant register: parked in reset, moves only when the bus is free.
    always_ff @(posedge clk) begin
        if (!rst_n)          agnt_q <= park_vec;
        else if (may_change) agnt_q <= nxt_vec;
    end

    assign agnt       = agnt_q;
    assign abusy      = abusy_q;
    assign rr_ptr     = rr_q;
    assign push       = ending && !artry_in;
    assign push_id    = own_q;
    assign push_burst = bst_q;

    AST_AGNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(agnt_q));                                                    // R12
    AST_AGNT_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        abusy_q && !aack_in |=> $stable(agnt_q));                             // R6
    AST_ABUSY_NEEDS_TS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abusy_q) |-> $past(ts_in) && !$past(artry_in));                 // R5
endmodule

// File: rtl/sbarb_data_trk.sv
// Data-bus side: issues data grants from the queue head and counts beats.
// Assumes: ta_in only pulses during a data tenure it belongs to.
module sbarb_data_trk #(
    parameter int N     = 4,
    parameter int IDW   = 2,
    parameter int BEATS = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ta_in,
    input  logic           artry_in,
    input  logic           q_empty,
    input  logic [IDW-1:0] q_id,
    input  logic           q_burst,
    output logic [N-1:0]   dgnt,
    output logic           dbusy,
    output logic           pop
);
    localparam int BW = $clog2(BEATS + 1);

    logic [N-1:0]  dgnt_q, head_vec;
    logic          dbusy_q, take, last_beat;
    logic [BW-1:0] left_q;

    // One-hot of the queue head, zero when empty.
    always_comb begin
        for (int i = 0; i < N; i++) head_vec[i] = !q_empty && (q_id == IDW'(i));
    end

    assign take      = !dbusy_q && (|dgnt_q) && !artry_in;
    assign last_beat = dbusy_q && ta_in && (left_q == BW'(1));

    // Busy flag and remaining-beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbusy_q <= 1'b0;
            left_q  <= '0;
        end else if (take) begin
            dbusy_q <= 1'b1;
            left_q  <= q_burst ? BW'(BEATS) : BW'(1);
        end else if (dbusy_q && ta_in) begin
            left_q <= left_q - BW'(1);
            if (left_q == BW'(1)) dbusy_q <= 1'b0;
        end
    end

    // Data grant: hand-off at the final beat, or load when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                              dgnt_q <= '0;
        else if (last_beat)                      dgnt_q <= head_vec;
        else if (!dbusy_q && (dgnt_q == '0))     dgnt_q <= head_vec;
    end

    assign dgnt  = dgnt_q;
    assign dbusy = dbusy_q;
    assign pop   = take;

    AST_DGNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dgnt_q));                                                    // R12
    AST_DBUSY_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbusy_q) |-> ($past(dgnt_q) != '0) && !$past(artry_in));        // R8
    AST_DGNT_HELD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        dbusy_q && !ta_in |=> $stable(dgnt_q));                               // R9
endmodule

// File: rtl/split_tenure_arbiter.sv
// Top: separate address and data arbitration with an in-order tenure queue.
// Assumes: static level/park configuration; one active address master at a time.
module split_tenure_arbiter #(
    parameter int NUM_M       = 4,
    parameter int Q_DEPTH     = 2,
    parameter int BURST_BEATS = sbarb_pkg::DEF_BURST_BEATS,
    localparam int IDW        = (NUM_M > 1) ? $clog2(NUM_M) : 1,
    localparam int LVL_W      = sbarb_pkg::LVL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_M-1:0]       bus_req,
    input  logic [NUM_M*LVL_W-1:0] lvl_cfg,
    input  logic [IDW-1:0]         park_sel,
    input  logic                   ts_in,
    input  logic                   burst_in,
    input  logic                   aack_in,
    input  logic                   artry_in,
    input  logic                   ta_in,
    output logic [NUM_M-1:0]       addr_gnt,
    output logic [NUM_M-1:0]       data_gnt,
    output logic                   addr_busy,
    output logic                   data_busy
);
    logic           any_req, push, pop, q_empty, q_full_nxt, push_burst;
    logic [IDW-1:0] win_id, rr_ptr, push_id;
    logic [IDW:0]   q_dout;

    sbarb_prio_pick #(.N(NUM_M), .LVL_W(LVL_W), .IDW(IDW)) u_pick (
        .req(bus_req), .lvl(lvl_cfg), .rr_ptr(rr_ptr),
        .any_req(any_req), .win_id(win_id)
    );

    sbarb_addr_trk #(.N(NUM_M), .IDW(IDW)) u_addr (
        .clk(clk), .rst_n(rst_n), .ts_in(ts_in), .burst_in(burst_in),
        .aack_in(aack_in), .artry_in(artry_in), .any_req(any_req),
        .win_id(win_id), .park_id(park_sel), .block_grant(q_full_nxt),
        .agnt(addr_gnt), .abusy(addr_busy), .rr_ptr(rr_ptr),
        .push(push), .push_id(push_id), .push_burst(push_burst)
    );

    sbarb_order_fifo #(.DEPTH(Q_DEPTH), .W(IDW+1)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(push), .din({push_burst, push_id}),
        .pop(pop), .dout(q_dout), .empty(q_empty), .full_next(q_full_nxt)
    );

    sbarb_data_trk #(.N(NUM_M), .IDW(IDW), .BEATS(BURST_BEATS)) u_data (
        .clk(clk), .rst_n(rst_n), .ta_in(ta_in), .artry_in(artry_in),
        .q_empty(q_empty), .q_id(q_dout[IDW-1:0]), .q_burst(q_dout[IDW]),
        .dgnt(data_gnt), .dbusy(data_busy), .pop(pop)
    );

    AST_RETRY_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        artry_in |-> !push);                                                  // R7
    AST_FULL_NO_AGNT: assert property (@(posedge clk) disable iff (!rst_n)
        q_full_nxt && !addr_busy |=> (addr_gnt == '0));                       // R11
endmodule

// File: tb/tb_split_tenure_arbiter.sv
module tb_split_tenure_arbiter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  req;
    logic [11:0] lvl;
    logic [1:0]  park;
    logic        ts, burst, aack, artry, ta;
    logic [3:0]  agnt, dgnt;
    logic        abusy, dbusy;
    int          checks = 0, errors = 0, rr_m = 0;

    always #2.5 clk = ~clk;

    split_tenure_arbiter dut (
        .clk(clk), .rst_n(rst_n), .bus_req(req), .lvl_cfg(lvl), .park_sel(park),
        .ts_in(ts), .burst_in(burst), .aack_in(aack), .artry_in(artry), .ta_in(ta),
        .addr_gnt(agnt), .data_gnt(dgnt), .addr_busy(abusy), .data_busy(dbusy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Expected grant: highest level, first in rotation order from rr; park if idle.
    function automatic logic [3:0] model(logic [3:0] r, logic [11:0] l, int rr, int pk);
        int best = -1;
        for (int k = 0; k < 4; k++) begin
            int i = (rr + k) % 4;
            if (r[i] && (best < 0 || l[3*i +: 3] > l[3*best +: 3])) best = i;
        end
        if (best < 0) best = pk;
        return 4'b1 << best;
    endfunction

    function automatic int idx(logic [3:0] v);
        int r = 0;
        for (int i = 0; i < 4; i++) if (v[i]) r = i;
        return r;
    endfunction

    task automatic addr_tenure(input int id, input logic b);
        ts = 1'b1; burst = b; step(); ts = 1'b0; burst = 1'b0;
        chk("R5 busy after start", abusy, 1);
        rr_m = (id + 1) % 4;
        aack = 1'b1; step(); aack = 1'b0;
        chk("R6 busy cleared", abusy, 0);
    endtask

    task automatic data_tenure(input int id, input int beats);
        step(); chk("R8 data grant", dgnt, 4'b1 << id);
        step(); chk("R8 data busy", dbusy, 1);
        for (int k = 1; k < beats; k++) begin
            ta = 1'b1; step(); ta = 1'b0;
            chk("R9 mid beat", dbusy, 1);
        end
        ta = 1'b1; step(); ta = 1'b0;
        chk("R9 last beat", dbusy, 0);
        chk("R9 grant released", dgnt, 0);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        rst_n = 1'b0; req = '0; lvl = '0; park = 2'd2;
        ts = 0; burst = 0; aack = 0; artry = 0; ta = 0;
        repeat (3) step();
        chk("R1 reset park", agnt, 4'b0100);
        chk("R1 reset dgnt", dgnt, 0);
        chk("R1 reset busy", {abusy, dbusy}, 0);
        park = 2'd3; step();
        chk("R1 park follows in reset", agnt, 4'b1000);
        rst_n = 1'b1; step();
        chk("R2 idle parked", agnt, 4'b1000);
        park = 2'd1; step();
        chk("R2 park moved", agnt, 4'b0010);

        // Exhaustive request sweep under three level maps, pointer at 0.
        for (int c = 0; c < 3; c++) begin
            lvl = (c == 0) ? 12'h000 : (c == 1) ? {3'd1, 3'd3, 3'd3, 3'd7} : {3'd5, 3'd2, 3'd5, 3'd2};
            for (int r = 0; r < 16; r++) begin
                req = 4'(r); step();
                chk("R3 priority sweep", agnt, model(req, lvl, rr_m, park));
            end
        end

        // Round-robin among equal levels.
        lvl = {4{3'd4}}; req = 4'b1111; step();
        for (int t = 0; t < 5; t++) begin
            int id;
            chk("R4 rotation", agnt, model(req, lvl, rr_m, park));
            id = idx(agnt);
            addr_tenure(id, 1'b0);
            chk("R4 next after end", agnt, model(req, lvl, rr_m, park));
            data_tenure(id, 1);
        end

        // Retry handling.
        req = 4'b0001; step();
        chk("R3 single requester", agnt, 4'b0001);
        ts = 1; artry = 1; step(); ts = 0; artry = 0;
        chk("R5 start under retry ignored", abusy, 0);
        ts = 1; step(); ts = 0; rr_m = 1;
        chk("R5 start accepted", abusy, 1);
        chk("R6 grant held", agnt, 4'b0001);
        aack = 1; artry = 1; step(); aack = 0; artry = 0;
        chk("R7 busy cleared", abusy, 0);
        repeat (3) step();
        chk("R7 no data grant", {dgnt, dbusy}, 0);

        // Address tenure overlapping a burst data tenure.
        req = 4'b0010; step();
        chk("R3 grant m1", agnt, 4'b0010);
        addr_tenure(1, 1'b1);
        step(); chk("R8 grant m1 data", dgnt, 4'b0010);
        req = 4'b0100; step();
        chk("R8 data busy", dbusy, 1);
        chk("R10 addr grant during data", agnt, 4'b0100);
        ts = 1; step(); ts = 0; rr_m = 3;
        chk("R10 overlap", {abusy, dbusy}, 2'b11);
        aack = 1; step(); aack = 0;
        for (int k = 0; k < 3; k++) begin
            ta = 1; step(); ta = 0;
            chk("R9 burst mid beat", dbusy, 1);
        end
        ta = 1; step(); ta = 0;
        chk("R9 burst done", dbusy, 0);
        chk("R8 order hand-off", dgnt, 4'b0100);
        step(); chk("R8 second tenure busy", dbusy, 1);
        ta = 1; step(); ta = 0;
        chk("R9 single done", {dgnt, dbusy}, 0);

        // Queue-full gating.
        req = 4'b0001; step();
        chk("R11 grant m0", agnt, 4'b0001);
        addr_tenure(0, 1'b0);
        step(); step();
        chk("R11 A data busy", dbusy, 1);
        req = 4'b0010; step();
        chk("R11 grant m1", agnt, 4'b0010);
        addr_tenure(1, 1'b0);
        req = 4'b0100; step();
        chk("R11 grant m2", agnt, 4'b0100);
        addr_tenure(2, 1'b0);
        chk("R11 blocked when full", agnt, 0);
        step(); chk("R11 still blocked", agnt, 0);
        ta = 1; step(); ta = 0;
        chk("R8 hand-off to m1", dgnt, 4'b0010);
        chk("R11 blocked before pop", agnt, 0);
        step();
        chk("R11 regranted after pop", agnt, 4'b0100);
        chk("R8 m1 data busy", dbusy, 1);
        ta = 1; step(); ta = 0;
        chk("R8 hand-off to m2", dgnt, 4'b0100);
        step(); ta = 1; step(); ta = 0;
        chk("R9 queue drained", {dgnt, dbusy}, 0);
        chk("R12 grant shape", $countones(agnt) <= 1, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule